// File: doc/BRIEF.md
# System Clock Source Switcher

This block decides which of two oscillators paces the core: a slow secondary oscillator that is always running, or the main oscillator. Software asks for the main oscillator by setting a single select input. The block does not hand the core over at once. It first qualifies the main oscillator with a waiting period that depends on a three-bit mode code, which is captured when the request begins. Crystal modes wait out a start-up count of main-oscillator periods. The PLL crystal mode then adds a lock timeout, counted in reference-clock cycles. The RC and external-clock modes need only a short count of eight main periods. Until the wait is over, the secondary oscillator keeps driving the core.

Both oscillators reach the block as single-cycle tick strobes in one reference clock domain. The selected tick drives a four-phase ring (Q1 to Q4). Each full ring pass is one instruction cycle and adds 2 to a program-counter output, so execution carries on through the whole transition. The source changes only at the end of a Q4 phase of the outgoing source, so no phase is ever cut short. A status output reports that the main oscillator is in control. It drops in the same cycle that the select input is cleared. Clearing the select input during qualification aborts the wait.

Top module: `sysclk_switch`

## Requirements
- R1: While reset is held, `q_phase` is 4'b0001 (Q1), `pc` is 0, and `qual_busy` and `main_active` are 0.
- R2: `q_phase` is one-hot, with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. It moves one phase forward (Q4 wraps to Q1) on every clock edge that samples a tick of the active source, and holds otherwise.
- R3: `pc` increases by 2 on each Q4-to-Q1 wrap and is otherwise unchanged.
- R4: With `osc_mode` 0, 1 or 2 (crystal modes without PLL), qualification ends on the edge that samples the OST_CYCLES-th main tick after the request edge.
- R5: With `osc_mode` 3 (crystal with PLL), qualification first counts OST_CYCLES main ticks and then PLL_LOCK_CYCLES further reference-clock edges. It ends on the last of those edges.
- R6: With `osc_mode` 4 to 7 (RC, RC with I/O, external clock, external clock with I/O), there is no start-up count. Qualification ends on the edge that samples the SETTLE_CYCLES-th main tick (eight by default).
- R7: `osc_mode` is captured on the edge where a request is first seen. Changing it during qualification has no effect on the wait.
- R8: The active source becomes the main oscillator only after qualification has ended. The change happens at a Q4-to-Q1 wrap of the secondary ring, so `main_active` rises together with `q_phase` entering Q1.
- R9: Before the switch, the ring advances only on `sec_tick`. After the switch, it advances only on `main_tick`.
- R10: Clearing `clk_sel` during qualification aborts it. `qual_busy` falls on the next edge, and the secondary oscillator stays in control even if the final count tick arrives on that same edge. A new request starts the count again from zero.
- R11: `main_active` goes low in the same cycle that `clk_sel` goes low. The source returns to the secondary oscillator at the next Q4-to-Q1 wrap of the main ring.
- R12: `qual_busy` is high from the edge after the request is sampled until the edge on which qualification ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 1 | 1 requests the main oscillator, 0 requests the secondary |
| osc_mode | input | 3 | Main-oscillator mode code (0-2 crystal, 3 crystal with PLL, 4-7 RC/external) |
| sec_tick | input | 1 | One-cycle strobe per secondary-oscillator period |
| main_tick | input | 1 | One-cycle strobe per main-oscillator period |
| sys_tick | output | 1 | Tick of the source currently in control |
| q_phase | output | 4 | One-hot instruction phase, bit 0 = Q1 to bit 3 = Q4 |
| pc | output | PC_W | Program counter, +2 per instruction cycle |
| qual_busy | output | 1 | Main-oscillator qualification in progress |
| main_active | output | 1 | Main oscillator is driving the system clock |

## Verification
The critical coincidence is between an abort and the completion of qualification. A clear of `clk_sel` can land on the very edge that samples the final settle tick. The bench provokes this by dropping the select input at the moment it raises the eighth main tick of an RC-mode wait. It then judges the outcome at the ports: `qual_busy` falls, `main_active` stays low, and the ring keeps following `sec_tick`. A fresh request is then timed to show a full count from zero. A second overlap is a source change landing on a ring wrap. The bench checks this on every switch: `main_active` must rise in the same cycle that `q_phase` moves from Q4 to Q1.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  // Main-oscillator mode codes (bit 2 clear = crystal family)
  typedef enum logic [2:0] {
    OM_LP    = 3'd0,
    OM_XT    = 3'd1,
    OM_HS    = 3'd2,
    OM_HSPLL = 3'd3,
    OM_RC    = 3'd4,
    OM_RCIO  = 3'd5,
    OM_EC    = 3'd6,
    OM_ECIO  = 3'd7
  } osc_mode_e;

  // Qualification sequencer states
  typedef enum logic [2:0] {
    QS_IDLE   = 3'd0,
    QS_START  = 3'd1,
    QS_LOCK   = 3'd2,
    QS_SETTLE = 3'd3,
    QS_DONE   = 3'd4
  } qual_state_e;

  function automatic logic mode_is_crystal(input osc_mode_e m);
    return (m == OM_LP) || (m == OM_XT) || (m == OM_HS) || (m == OM_HSPLL);
  endfunction

  function automatic logic mode_has_pll(input osc_mode_e m);
    return m == OM_HSPLL;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int t;
    t = (a > b) ? a : b;
    return (t > c) ? t : c;
  endfunction

endpackage

// File: rtl/sysclk_qualifier.sv
module sysclk_qualifier
  import sysclk_pkg::*;
#(
  parameter int OST_CYCLES      = 1024,
  parameter int PLL_LOCK_CYCLES = 4096,
  parameter int SETTLE_CYCLES   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [2:0] mode,
  input  logic       main_tick,
  output logic       busy,
  output logic       ready
);

  localparam int MAX_CNT = max3(OST_CYCLES, PLL_LOCK_CYCLES, SETTLE_CYCLES);
  localparam int CNT_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;
  localparam logic [CNT_W-1:0] START_LAST  = CNT_W'(OST_CYCLES - 1);
  localparam logic [CNT_W-1:0] LOCK_LAST   = CNT_W'(PLL_LOCK_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_ONE     = CNT_W'(1);

  qual_state_e      state;
  osc_mode_e        mode_q;
  logic [CNT_W-1:0] cnt;
  osc_mode_e        mode_in;

  assign mode_in = osc_mode_e'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= QS_IDLE;
      mode_q <= OM_LP;
      cnt    <= '0;
    end else begin
      case (state)
        QS_IDLE: begin
          cnt <= '0;
          if (req) begin
            mode_q <= mode_in;
            state  <= mode_is_crystal(mode_in) ? QS_START : QS_SETTLE;
          end
        end
        QS_START: begin
          if (!req) begin
            state <= QS_IDLE;
            cnt   <= '0;
          end else if (main_tick) begin
            if (cnt == START_LAST) begin
              cnt   <= '0;
              state <= mode_has_pll(mode_q) ? QS_LOCK : QS_DONE;
            end else begin
              cnt <= cnt + CNT_ONE;
            end
          end
        end
        QS_LOCK: begin
          if (!req) begin
            state <= QS_IDLE;
            cnt   <= '0;
          end else if (cnt == LOCK_LAST) begin
            cnt   <= '0;
            state <= QS_DONE;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
        QS_SETTLE: begin
          if (!req) begin
            state <= QS_IDLE;
            cnt   <= '0;
          end else if (main_tick) begin
            if (cnt == SETTLE_LAST) begin
              cnt   <= '0;
              state <= QS_DONE;
            end else begin
              cnt <= cnt + CNT_ONE;
            end
          end
        end
        QS_DONE: begin
          cnt <= '0;
          if (!req) state <= QS_IDLE;
        end
        default: begin
          state <= QS_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign busy  = (state == QS_START) || (state == QS_LOCK) || (state == QS_SETTLE);
  assign ready = (state == QS_DONE);

endmodule

// File: rtl/sysclk_src_sel.sv
module sysclk_src_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic want_main,
  input  logic sec_tick,
  input  logic main_tick,
  input  logic at_q4,
  output logic src_main,
  output logic sys_tick
);

  logic wrap_edge;

  assign sys_tick  = src_main ? main_tick : sec_tick;
  assign wrap_edge = sys_tick && at_q4;

  // Source changes only as the outgoing ring leaves Q4
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_main <= 1'b0;
    end else if (wrap_edge && (src_main != want_main)) begin
      src_main <= want_main;
    end
  end

endmodule

// File: rtl/sysclk_qphase.sv
module sysclk_qphase #(
  parameter int NPH  = 4,
  parameter int PC_W = 16,
  parameter int PC_STEP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [NPH-1:0]  phase,
  output logic            at_last,
  output logic [PC_W-1:0] pc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);
  localparam logic [NPH-1:0]  FIRST = NPH'(1);

  logic [NPH-1:0] phase_nxt;

  for (genvar i = 0; i < NPH; i++) begin : g_ring
    assign phase_nxt[i] = phase[(i + NPH - 1) % NPH];
  end

  assign at_last = phase[NPH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= FIRST;
      pc    <= '0;
    end else if (adv) begin
      phase <= phase_nxt;
      if (at_last) pc <= pc + STEP;
    end
  end

endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch #(
  parameter int OST_CYCLES      = 1024,
  parameter int PLL_LOCK_CYCLES = 4096,
  parameter int SETTLE_CYCLES   = 8,
  parameter int PC_W            = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_sel,
  input  logic [2:0]      osc_mode,
  input  logic            sec_tick,
  input  logic            main_tick,
  output logic            sys_tick,
  output logic [3:0]      q_phase,
  output logic [PC_W-1:0] pc,
  output logic            qual_busy,
  output logic            main_active
);

  logic q_ready;
  logic src_main;
  logic at_q4;
  logic want_main;

  sysclk_qualifier #(
    .OST_CYCLES      (OST_CYCLES),
    .PLL_LOCK_CYCLES (PLL_LOCK_CYCLES),
    .SETTLE_CYCLES   (SETTLE_CYCLES)
  ) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (clk_sel),
    .mode      (osc_mode),
    .main_tick (main_tick),
    .busy      (qual_busy),
    .ready     (q_ready)
  );

  assign want_main = q_ready && clk_sel;

  sysclk_src_sel u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .want_main (want_main),
    .sec_tick  (sec_tick),
    .main_tick (main_tick),
    .at_q4     (at_q4),
    .src_main  (src_main),
    .sys_tick  (sys_tick)
  );

  sysclk_qphase #(
    .NPH     (4),
    .PC_W    (PC_W),
    .PC_STEP (2)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (sys_tick),
    .phase   (q_phase),
    .at_last (at_q4),
    .pc      (pc)
  );

  assign main_active = src_main && want_main;

endmodule

// File: rtl/sysclk_switch_chk.sv
module sysclk_switch_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clk_sel,
  input logic            sys_tick,
  input logic [3:0]      q_phase,
  input logic [PC_W-1:0] pc,
  input logic            qual_busy,
  input logic            main_active,
  input logic            src_main,
  input logic            ready
);

  p_onehot_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q_phase) == 1);

  p_phase_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick |=> q_phase == {$past(q_phase[2:0]), $past(q_phase[3])});

  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_tick |=> $stable(q_phase));

  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_tick && q_phase[3]) |=> pc == $past(pc) + PC_W'(2));

  p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_tick && q_phase[3]) |=> $stable(pc));

  p_switch_at_q1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_main) |-> (q_phase[0] && $past(q_phase[3])));

  p_switch_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_main) |-> $past(ready));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_busy && !clk_sel) |=> !qual_busy);

  p_status_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_sel |-> !main_active);

  p_return_at_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src_main) |-> (q_phase[0] && $past(q_phase[3])));

endmodule

bind sysclk_switch sysclk_switch_chk #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_sel     (clk_sel),
  .sys_tick    (sys_tick),
  .q_phase     (q_phase),
  .pc          (pc),
  .qual_busy   (qual_busy),
  .main_active (main_active),
  .src_main    (src_main),
  .ready       (q_ready)
);

// File: tb/sim_sysclk_switch.sv
module sim_sysclk_switch;

  localparam int OST     = 16;
  localparam int PLL     = 40;
  localparam int SETTLE  = 8;
  localparam int PCW     = 16;
  localparam int SEC_DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       sel_req = 1'b0;
  logic       kill = 1'b0;
  logic       clk_sel;
  logic [2:0] osc_mode = 3'd0;
  logic       sec_tick = 1'b0;
  logic       main_tick = 1'b0;
  logic       sys_tick;
  logic [3:0] q_phase;
  logic [PCW-1:0] pc;
  logic       qual_busy;
  logic       main_active;

  assign clk_sel = sel_req && !kill;

  sysclk_switch #(
    .OST_CYCLES      (OST),
    .PLL_LOCK_CYCLES (PLL),
    .SETTLE_CYCLES   (SETTLE),
    .PC_W            (PCW)
  ) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_sel     (clk_sel),
    .osc_mode    (osc_mode),
    .sec_tick    (sec_tick),
    .main_tick   (main_tick),
    .sys_tick    (sys_tick),
    .q_phase     (q_phase),
    .pc          (pc),
    .qual_busy   (qual_busy),
    .main_active (main_active)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor and tick generator state
  int       main_div = 2;
  int       mcnt = 0;
  int       scnt = 0;
  int       thr = SETTLE;
  int       ticks_q = 0;
  int       extra_q = 0;
  bit       done_flag = 1'b0;
  bit       busy_last = 1'b0;
  bit       act_last = 1'b0;
  bit       chk_en = 1'b0;
  bit       abort_arm = 1'b0;
  logic [3:0] q_last = 4'b0001;
  longint   wraps = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_last) begin
        if (ticks_q < thr) begin
          if (main_tick) ticks_q++;
        end else begin
          extra_q++;
        end
        if (!qual_busy) done_flag = 1'b1;
      end
      if (chk_en)
        chk("R9", "ring advance vs active-source tick",
            longint'(q_phase != q_last), longint'(act_last ? main_tick : sec_tick));
      if (q_phase != q_last)
        chk("R2", "phase rotation", q_phase, {q_last[2:0], q_last[3]});
      if (q_last[3] && q_phase[0]) wraps++;
      if (main_active && !act_last) begin
        chk("R8", "q_phase when main takes over", q_phase, 4'b0001);
        chk("R8", "q_phase just before takeover", q_last, 4'b1000);
      end
      busy_last = qual_busy;
      q_last    = q_phase;
      act_last  = main_active;
    end
    mcnt = (mcnt + 1 >= main_div) ? 0 : mcnt + 1;
    main_tick = (mcnt == 0);
    scnt = (scnt + 1 >= SEC_DIV) ? 0 : scnt + 1;
    sec_tick = (scnt == 0);
    // abort lands on the edge that samples the final settle tick
    if (abort_arm && busy_last && ticks_q == SETTLE - 1 && main_tick) begin
      kill = 1'b1;
      abort_arm = 1'b0;
    end
  end

  task automatic run_switch(input int m, input int p, input bit change_mode);
    string rq;
    int exp_extra;
    @(negedge clk);
    main_div  = p;
    osc_mode  = 3'(m);
    thr       = (m < 4) ? OST : SETTLE;
    exp_extra = (m == 3) ? PLL : 0;
    rq        = (m < 3) ? "R4" : ((m == 3) ? "R5" : "R6");
    ticks_q   = 0;
    extra_q   = 0;
    done_flag = 1'b0;
    @(negedge clk);
    sel_req = 1'b1;
    @(negedge clk);
    chk("R12", "busy after request edge", qual_busy, 1);
    if (change_mode) begin
      repeat (3) @(negedge clk);
      osc_mode = 3'd3;
    end
    for (int i = 0; i < 3000 && !done_flag; i++) @(negedge clk);
    chk("R12", "qualification ended", done_flag, 1);
    chk(change_mode ? "R7" : rq, "main ticks counted", ticks_q, thr);
    chk(change_mode ? "R7" : rq, "extra lock edges", extra_q, exp_extra);
    for (int i = 0; i < 200 && !main_active; i++) @(negedge clk);
    chk("R8", "main active after qualification", main_active, 1);
    repeat (30) @(negedge clk);
    chk("R9", "still on main", main_active, 1);
    chk("R3", "pc vs instruction cycles", pc, PCW'(2 * wraps));
    sel_req = 1'b0;
    chk_en  = 1'b0;
    #1;
    chk("R11", "status drops with select", main_active, 0);
    repeat (30) @(negedge clk);
    chk_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset phase", q_phase, 4'b0001);
    chk("R1", "reset pc", pc, 0);
    chk("R1", "reset busy", qual_busy, 0);
    chk("R1", "reset active", main_active, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk_en = 1'b1;
    chk("R9", "secondary drives ring before request", main_active, 0);

    for (int p = 1; p <= 3; p++)
      for (int m = 0; m < 8; m++)
        run_switch(m, p, 1'b0);

    // R7: mode changed mid-wait from RC to PLL crystal
    run_switch(4, 2, 1'b1);

    // R10: abort coinciding with final settle tick
    @(negedge clk);
    main_div = 2; osc_mode = 3'd4; thr = SETTLE;
    ticks_q = 0; extra_q = 0; done_flag = 1'b0;
    abort_arm = 1'b1;
    @(negedge clk);
    sel_req = 1'b1;
    for (int i = 0; i < 500 && !kill; i++) @(negedge clk);
    chk("R10", "abort triggered", kill, 1);
    @(negedge clk);
    chk("R10", "busy falls after abort", qual_busy, 0);
    chk("R10", "no switch on abort edge", main_active, 0);
    repeat (60) @(negedge clk);
    chk("R10", "secondary kept after abort", main_active, 0);
    sel_req = 1'b0;
    kill = 1'b0;
    repeat (5) @(negedge clk);
    run_switch(4, 2, 1'b0);

    chk("R3", "final pc", pc, PCW'(2 * wraps));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule